// File: doc/BRIEF.md
# Triple-Lane Voted Pipeline

This block moves 13-bit syllables through a seven-stage pipeline that exists in three identical copies, called lanes. After every stage, a bitwise two-out-of-three voter combines the three lanes. The voted word is then loaded into the next stage register of every lane. A single corrupted lane register at any stage is therefore outvoted one cycle later and overwritten with the correct value. The fault does not travel downstream.

Each input syllable carries an odd-parity bit as its fourteenth bit. The parity is checked on entry, and the error flag travels with the word. The stage operation is a pass-through, so the 4-bit opcode field and the 9-bit address field arrive at the outputs unchanged. Fault-injection inputs let a testbench overwrite one lane register for one cycle. Per-stage disagreement outputs report which lane was outvoted.

Top module: `tmr_voted_pipe`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is zero.
- R2: A word presented in cycle c appears at the outputs in cycle c+7, with its valid bit. The opcode `out_opc` is syllable bits 12:9 and the address `out_addr` is bits 8:0, both unchanged.
- R3: `in_syl[13]` is the parity bit. A valid input whose 14 bits hold an even number of ones has a parity error. That error appears on `out_perr` together with the word, seven cycles later.
- R4: An input with `in_vld` low never produces a parity error, whatever its bits are. It leaves the pipeline with `out_vld` and `out_perr` both low.
- R5: When `inj_en` is high, `inj_val` is loaded for one cycle into the register of lane `inj_lane` at stage `inj_stage`, instead of its normal input. `inj_val` bit 14 is valid, bit 13 is parity error, and bits 12:0 are the syllable.
- R6: A single injected lane fault, at any stage and in any lane, never changes the outputs.
- R7: In the cycle after an injection whose value differs from the correct stage content, `mis_flag[s]` is high for the injected stage s. In that same cycle `mis_lane[3*s+l]` names the injected lane l.
- R8: One cycle after a flagged disagreement, all flags are low again, because the faulty lane has been reloaded from the vote.
- R9: Without injection, every `mis_flag` and `mis_lane` bit stays low.
- R10: An injection whose value equals the correct stage content raises no flag.
- R11: An injection with `inj_stage` of 7 or above, or with `inj_lane` equal to 3, changes no register and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_syl | input | 14 | Odd-parity bit (13) and syllable (12:0) |
| inj_en | input | 1 | Fault injection enable |
| inj_stage | input | 3 | Stage to corrupt |
| inj_lane | input | 2 | Lane to corrupt (0..2) |
| inj_val | input | 15 | Value forced into the register |
| out_vld | output | 1 | Voted valid bit from the last stage |
| out_perr | output | 1 | Voted parity error |
| out_opc | output | 4 | Voted opcode field |
| out_addr | output | 9 | Voted address field |
| mis_flag | output | 7 | Per-stage disagreement flag |
| mis_lane | output | 21 | Dissenting lane, three bits per stage |

## Verification
The bench injects faults into every stage and every lane, with random multi-bit corruptions. It checks that the output stream stays bit-exact. A design that voted only at the end, or that did not reload lanes from the vote, would let errors accumulate into a wrong output, or would leave flags stuck high after the fault cycle. It also drives injections that equal the correct value and injections addressed to stage 7, where a flag would reveal a voter that compares against the wrong lane or a decoder that wraps. Directed parity cases (all-ones syllable, even-parity word, invalid word with bad parity) catch a checker with the wrong sense or one that ignores the valid bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SYL_W    = 13;
  localparam int OPC_W    = 4;
  localparam int N_STAGES = 7;
  localparam int N_LANES  = 3;
endpackage

// File: rtl/tmr_vote3.sv
module tmr_vote3 #(
  parameter int W = 15
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic [2:0]   dissent
);
  // bitwise two-out-of-three
  assign y = (a & b) | (a & c) | (b & c);

  // a lane dissents when any of its bits differs from the voted word
  assign dissent = {|(c ^ y), |(b ^ y), |(a ^ y)};
endmodule

// File: rtl/tmr_lane_reg.sv
module tmr_lane_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic         frc_en,
  input  logic [W-1:0] frc_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (frc_en) q <= frc_val;
    else             q <= d;
  end
endmodule

// File: rtl/tmr_voted_pipe.sv
module tmr_voted_pipe
  import tmr_pkg::*;
#(
  parameter int DATA_W  = SYL_W,
  parameter int FIELD_W = OPC_W,
  parameter int STAGES  = N_STAGES,
  localparam int RW     = DATA_W + 2,
  localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic [DATA_W:0]            in_syl,
  input  logic                       inj_en,
  input  logic [SEL_W-1:0]           inj_stage,
  input  logic [1:0]                 inj_lane,
  input  logic [RW-1:0]              inj_val,
  output logic                       out_vld,
  output logic                       out_perr,
  output logic [FIELD_W-1:0]         out_opc,
  output logic [DATA_W-FIELD_W-1:0]  out_addr,
  output logic [STAGES-1:0]          mis_flag,
  output logic [N_LANES*STAGES-1:0]  mis_lane
);
  // word layout inside the pipe: {valid, parity error, syllable}
  logic          in_perr;
  logic [RW-1:0] in_beat;
  assign in_perr = in_vld & ~(^in_syl);
  assign in_beat = {in_vld, in_perr, in_syl[DATA_W-1:0]};

  logic [RW-1:0] lane_q  [STAGES][N_LANES];
  logic [RW-1:0] voted   [STAGES];
  logic [2:0]    dissent [STAGES];

  // armed goes high one cycle after reset releases, so $past never sees pre-reset values
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [RW-1:0] stage_d;
    if (k == 0) begin : g_head
      assign stage_d = in_beat;
    end else begin : g_body
      assign stage_d = voted[k-1];
    end

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      logic hit;
      assign hit = inj_en && (inj_stage == SEL_W'(k)) && (inj_lane == 2'(l));
      tmr_lane_reg #(.W(RW)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .d       (stage_d),
        .frc_en  (hit),
        .frc_val (inj_val),
        .q       (lane_q[k][l])
      );
    end

    tmr_vote3 #(.W(RW)) u_vote (
      .a       (lane_q[k][0]),
      .b       (lane_q[k][1]),
      .c       (lane_q[k][2]),
      .y       (voted[k]),
      .dissent (dissent[k])
    );

    assign mis_flag[k]                  = |dissent[k];
    assign mis_lane[N_LANES*k +: N_LANES] = dissent[k];

    // one injection port: at most one lane can ever dissent in a stage (R7)
    assert_one_dissenter_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dissent[k]));

    if (k == 0) begin : g_chk_head
      // the voted head stage always equals the word presented one cycle earlier (R2)
      assert_head_capture_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        voted[0] == $past(in_beat));
    end else begin : g_chk_body
      // a single corrupted lane never changes the voted word handed on (R6)
      assert_fault_masked_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        voted[k] == $past(voted[k-1]));
    end
  end

  assign out_vld  = voted[STAGES-1][RW-1];
  assign out_perr = voted[STAGES-1][RW-2];
  assign out_opc  = voted[STAGES-1][DATA_W-1 -: FIELD_W];
  assign out_addr = voted[STAGES-1][DATA_W-FIELD_W-1:0];

  // a parity error only ever travels with a valid word (R3, R4)
  assert_perr_needs_vld_R4: assert property (@(posedge clk) disable iff (rst)
    out_perr |-> out_vld);

  // no injection in the previous cycle means no disagreement now (R9)
  assert_quiet_without_fault_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(inj_en) |-> (mis_flag == '0));
endmodule

// File: tb/tmr_voted_pipe_bench.sv
module tmr_voted_pipe_bench;
  localparam int DW = 13;
  localparam int RW = 15;
  localparam int ST = 7;
  localparam int N_ITER = 600;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_vld;
  logic [DW:0]   in_syl;
  logic          inj_en;
  logic [2:0]    inj_stage;
  logic [1:0]    inj_lane;
  logic [RW-1:0] inj_val;
  logic          out_vld, out_perr;
  logic [3:0]    out_opc;
  logic [8:0]    out_addr;
  logic [ST-1:0]   mis_flag;
  logic [3*ST-1:0] mis_lane;

  always #5 clk = ~clk;

  tmr_voted_pipe u_tmr_voted_pipe (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_syl(in_syl),
    .inj_en(inj_en), .inj_stage(inj_stage), .inj_lane(inj_lane), .inj_val(inj_val),
    .out_vld(out_vld), .out_perr(out_perr), .out_opc(out_opc), .out_addr(out_addr),
    .mis_flag(mis_flag), .mis_lane(mis_lane)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [RW-1:0] hist [16];

  // expected pipe word from the requirements: {valid, parity error, syllable}
  function automatic logic [RW-1:0] beat_of(logic v, logic [DW:0] s);
    return {v, v & ~(^s), s[DW-1:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    logic [RW-1:0]   exp_beat;
    logic [ST-1:0]   exp_flag;
    logic [3*ST-1:0] exp_lane;
    string           flag_tag, dtag;
    int              last_inj;
    logic [DW-1:0]   s13;
    logic            p, v;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_vld = 1'b0; in_syl = '0;
    inj_en = 1'b0; inj_stage = '0; inj_lane = '0; inj_val = '0;
    for (int j = 0; j < 16; j++) hist[j] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {31'd0, out_vld}, 32'd0, "reset out_vld");
    chk("R1", {31'd0, out_perr}, 32'd0, "reset out_perr");
    chk("R1", {19'd0, out_opc, out_addr}, 32'd0, "reset fields");
    chk("R1", {25'd0, mis_flag}, 32'd0, "reset mis_flag");
    chk("R1", {11'd0, mis_lane}, 32'd0, "reset mis_lane");
    rst = 1'b0;
    exp_flag = '0; exp_lane = '0; flag_tag = "R9"; last_inj = -100;

    for (int i = 0; i < N_ITER; i++) begin
      @(negedge clk);
      exp_beat = (i >= 7) ? hist[(i-7) % 16] : '0;
      if (!exp_beat[RW-1])           dtag = "R4";
      else if (exp_beat[RW-2])       dtag = "R3";
      else if (i - last_inj <= 8)    dtag = "R6";
      else                           dtag = "R2";
      chk(dtag, {17'd0, out_vld, out_perr, out_opc, out_addr}, {17'd0, exp_beat}, "output word");
      chk(flag_tag, {25'd0, mis_flag}, {25'd0, exp_flag}, "mis_flag");
      chk(flag_tag, {11'd0, mis_lane}, {11'd0, exp_lane}, "mis_lane");

      flag_tag = (exp_flag != '0) ? "R8" : "R9";
      exp_flag = '0;
      exp_lane = '0;

      // stimulus: random words with occasional bad parity, plus directed corners
      s13 = DW'($urandom);
      v   = ($urandom % 8) != 0;
      p   = ~(^s13);
      if ($urandom % 6 == 0) p = ~p;
      if (i == 50) begin s13 = '1; v = 1'b1; p = 1'b0; end  // all ones, odd count
      if (i == 51) begin s13 = '0; v = 1'b1; p = 1'b0; end  // even count: error
      if (i == 52) begin s13 = '0; v = 1'b0; p = 1'b0; end  // invalid, bad parity
      in_vld = v;
      in_syl = {p, s13};
      hist[i % 16] = beat_of(v, {p, s13});

      if (i % 20 == 3) begin
        int n, s, l;
        logic [RW-1:0] mask, base;
        n = i / 20;
        s = n % 8;
        l = n % 3;
        mask = RW'($urandom);
        if (mask == '0) mask = 1;
        if (n % 9 == 4) mask = '0;
        base = (s < ST) ? hist[(i - s) % 16] : RW'($urandom);
        inj_en = 1'b1;
        inj_stage = 3'(s);
        inj_lane = 2'(l);
        inj_val = base ^ mask;
        last_inj = i;
        if (s >= ST)              flag_tag = "R11";
        else if (mask == '0)      flag_tag = "R10";
        else begin
          flag_tag = "R5 R7";
          exp_flag = ST'(1) << s;
          exp_lane = (3*ST)'(1) << (3*s + l);
        end
      end else begin
        inj_en = 1'b0;
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule